// File: doc/BRIEF.md
# AHB burst error-cancel filter

This block sits in the path between an AHB-Lite master and a downstream slave. Upstream it acts as a slave port, and downstream it acts as a master port. While no error has occurred, address, control and write data pass straight through to the downstream side. The downstream response and read data pass straight back, with no added latency.

When the downstream slave starts a two-cycle ERROR response, the filter cancels the transfer the upstream master already has pending. It does this by driving the downstream transfer type to IDLE in the second ERROR cycle. The ERROR itself is still passed back to the upstream master. The filter then enters a suppress mode. In that mode each SEQ beat the upstream master issues is kept off the downstream bus and is answered locally with a two-cycle ERROR. BUSY beats get a zero-wait OKAY. Suppress mode ends as soon as the master starts something new, and forwarding then resumes.

A bypass input selects plain pass-through behaviour. It is meant for buffered writes, because their slave responses never reach the master.

Top module: `ahb_err_cancel`

## Requirements
- R1: With no suppress mode active, `dn_htrans_o` equals `up_htrans_i` when `up_hsel_i` is high and IDLE when it is low. Address, write flag, size, burst and write data always pass through unchanged. `up_hready_o`, `up_hresp_o` and `up_hrdata_o` follow `dn_hready_i`, `dn_hresp_i` and `dn_hrdata_i`.
- R2: When a downstream ERROR first cycle (`dn_hresp_i`=1, `dn_hready_i`=0) is seen with `bypass_i` low, the next cycle drives `dn_htrans_o` to IDLE. The one exception is a selected NONSEQ on the upstream side in that cycle.
- R3: The downstream ERROR is returned upstream in both of its cycles, with `up_hresp_o`=1 and `up_hready_o` following `dn_hready_i`.
- R4: In suppress mode, an accepted SEQ beat is not forwarded. It is answered with a local ERROR: in the first cycle `up_hresp_o`=1 and `up_hready_o`=0, and in the second cycle `up_hresp_o`=1 and `up_hready_o`=1. `dn_htrans_o` stays IDLE in the first cycle.
- R5: In suppress mode, an accepted BUSY beat is not forwarded and gets a zero-wait OKAY (`up_hready_o`=1, `up_hresp_o`=0).
- R6: Suppress mode ends when an accepted upstream beat is NONSEQ or IDLE, or when `up_hsel_i` is low. A NONSEQ that ends it is forwarded in the same cycle.
- R7: If `bypass_i` is high during the downstream ERROR first cycle, there is no cancel and no suppress mode. Later beats are forwarded unchanged.
- R8: The encodings are HTRANS IDLE=0, BUSY=1, NONSEQ=2, SEQ=3, and HRESP OKAY=0, ERROR=1.
- R9: `rst_ni` low clears suppress mode asynchronously, and the block then behaves as in R1.
- R10: Every locally generated response drives `up_hrdata_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Disables error cancelling (buffered writes) |
| up_hsel_i | input | 1 | Upstream slave select |
| up_htrans_i | input | 2 | Upstream transfer type |
| up_haddr_i | input | AW | Upstream address |
| up_hwrite_i | input | 1 | Upstream write flag |
| up_hsize_i | input | 3 | Upstream transfer size |
| up_hburst_i | input | 3 | Upstream burst type |
| up_hwdata_i | input | DW | Upstream write data |
| up_hrdata_o | output | DW | Read data to upstream master |
| up_hready_o | output | 1 | Ready to upstream master |
| up_hresp_o | output | 1 | Response to upstream master |
| dn_htrans_o | output | 2 | Downstream transfer type |
| dn_haddr_o | output | AW | Downstream address |
| dn_hwrite_o | output | 1 | Downstream write flag |
| dn_hsize_o | output | 3 | Downstream transfer size |
| dn_hburst_o | output | 3 | Downstream burst type |
| dn_hwdata_o | output | DW | Downstream write data |
| dn_hrdata_i | input | DW | Read data from downstream slave |
| dn_hready_i | input | 1 | Ready from downstream slave |
| dn_hresp_i | input | 1 | Response from downstream slave |

## Verification
Two events can fall in the same cycle: the cancel in the second cycle of a downstream ERROR, and the start of a new upstream burst. The bench provokes this by having the slave fail the last beat of a burst while the master already presents the NONSEQ of the next burst through both ERROR cycles. The behavioural model expects that NONSEQ to reach the downstream bus in the cancel cycle, with the ERROR still passed upstream. From the next cycle it expects plain forwarding. Any IDLE in place of the NONSEQ, or any local ERROR after it, is reported as a miscompare.

// File: rtl/ecf_pkg.sv
package ecf_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } htrans_e;

  typedef enum logic [2:0] {
    ST_FWD    = 3'd0,  // plain forwarding
    ST_CANCEL = 3'd1,  // second cycle of downstream ERROR
    ST_SUP_OK = 3'd2,  // suppressing, local zero-wait OKAY data phase
    ST_SUP_E1 = 3'd3,  // suppressing, local ERROR first cycle
    ST_SUP_E2 = 3'd4   // suppressing, local ERROR second cycle
  } ecf_st_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/ecf_fsm.sv
module ecf_fsm
  import ecf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bypass_i,
  input  logic    sel_i,
  input  htrans_e trans_i,
  input  logic    dn_ready_i,
  input  logic    dn_resp_i,
  output ecf_st_e st_o
);
  ecf_st_e st_q, st_d, after_beat;
  logic    addr_taken;
  logic    dn_err_first;

  assign dn_err_first = !bypass_i && (dn_resp_i == RESP_ERROR) && !dn_ready_i;

  // upstream address phase completes in this cycle
  always_comb begin
    case (st_q)
      ST_CANCEL:            addr_taken = dn_ready_i;
      ST_SUP_OK, ST_SUP_E2: addr_taken = 1'b1;
      default:              addr_taken = 1'b0;
    endcase
  end

  always_comb begin
    after_beat = ST_FWD;
    if (sel_i) begin
      case (trans_i)
        TR_SEQ:  after_beat = ST_SUP_E1;
        TR_BUSY: after_beat = ST_SUP_OK;
        default: after_beat = ST_FWD;
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_FWD:    if (dn_err_first) st_d = ST_CANCEL;
      ST_SUP_E1: st_d = ST_SUP_E2;
      default:   if (addr_taken) st_d = after_beat;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_FWD;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/ecf_req_gate.sv
module ecf_req_gate
  import ecf_pkg::*;
(
  input  ecf_st_e st_i,
  input  logic    sel_i,
  input  htrans_e trans_i,
  output htrans_e dn_trans_o
);
  logic new_xfer;
  assign new_xfer = sel_i && (trans_i == TR_NONSEQ);

  always_comb begin
    case (st_i)
      ST_FWD:    dn_trans_o = sel_i ? trans_i : TR_IDLE;
      ST_SUP_E1: dn_trans_o = TR_IDLE;  // upstream address not yet accepted
      default:   dn_trans_o = new_xfer ? TR_NONSEQ : TR_IDLE;
    endcase
  end
endmodule

// File: rtl/ecf_resp_mux.sv
module ecf_resp_mux
  import ecf_pkg::*;
#(
  parameter int DW = 32
) (
  input  ecf_st_e         st_i,
  input  logic            dn_ready_i,
  input  logic            dn_resp_i,
  input  logic [DW-1:0]   dn_rdata_i,
  output logic            up_ready_o,
  output logic            up_resp_o,
  output logic [DW-1:0]   up_rdata_o
);
  always_comb begin
    up_ready_o = dn_ready_i;
    up_resp_o  = dn_resp_i;
    up_rdata_o = dn_rdata_i;
    case (st_i)
      ST_SUP_OK: begin
        up_ready_o = 1'b1;
        up_resp_o  = RESP_OKAY;
        up_rdata_o = '0;
      end
      ST_SUP_E1: begin
        up_ready_o = 1'b0;
        up_resp_o  = RESP_ERROR;
        up_rdata_o = '0;
      end
      ST_SUP_E2: begin
        up_ready_o = 1'b1;
        up_resp_o  = RESP_ERROR;
        up_rdata_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ahb_err_cancel.sv
module ahb_err_cancel
  import ecf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bypass_i,
  input  logic          up_hsel_i,
  input  logic [1:0]    up_htrans_i,
  input  logic [AW-1:0] up_haddr_i,
  input  logic          up_hwrite_i,
  input  logic [2:0]    up_hsize_i,
  input  logic [2:0]    up_hburst_i,
  input  logic [DW-1:0] up_hwdata_i,
  output logic [DW-1:0] up_hrdata_o,
  output logic          up_hready_o,
  output logic          up_hresp_o,
  output logic [1:0]    dn_htrans_o,
  output logic [AW-1:0] dn_haddr_o,
  output logic          dn_hwrite_o,
  output logic [2:0]    dn_hsize_o,
  output logic [2:0]    dn_hburst_o,
  output logic [DW-1:0] dn_hwdata_o,
  input  logic [DW-1:0] dn_hrdata_i,
  input  logic          dn_hready_i,
  input  logic          dn_hresp_i
);
  ecf_st_e st;
  htrans_e up_tr, dn_tr;

  assign up_tr = htrans_e'(up_htrans_i);

  ecf_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bypass_i   (bypass_i),
    .sel_i      (up_hsel_i),
    .trans_i    (up_tr),
    .dn_ready_i (dn_hready_i),
    .dn_resp_i  (dn_hresp_i),
    .st_o       (st)
  );

  ecf_req_gate i_req_gate (
    .st_i       (st),
    .sel_i      (up_hsel_i),
    .trans_i    (up_tr),
    .dn_trans_o (dn_tr)
  );

  ecf_resp_mux #(.DW(DW)) i_resp_mux (
    .st_i       (st),
    .dn_ready_i (dn_hready_i),
    .dn_resp_i  (dn_hresp_i),
    .dn_rdata_i (dn_hrdata_i),
    .up_ready_o (up_hready_o),
    .up_resp_o  (up_hresp_o),
    .up_rdata_o (up_hrdata_o)
  );

  assign dn_htrans_o = dn_tr;
  assign dn_haddr_o  = up_haddr_i;
  assign dn_hwrite_o = up_hwrite_i;
  assign dn_hsize_o  = up_hsize_i;
  assign dn_hburst_o = up_hburst_i;
  assign dn_hwdata_o = up_hwdata_i;
endmodule

// File: rtl/ecf_chk.sv
module ecf_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bypass_i,
  input logic          up_hsel_i,
  input logic [1:0]    up_htrans_i,
  input logic [DW-1:0] up_hrdata_o,
  input logic          up_hready_o,
  input logic          up_hresp_o,
  input logic [1:0]    dn_htrans_o,
  input logic          dn_hready_i,
  input logic          dn_hresp_i
);
  // R2
  cancel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_hresp_i && !dn_hready_i && !bypass_i) |=> (dn_htrans_o == 2'd0 || dn_htrans_o == 2'd2));

  // R3
  err_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_hresp_i |-> (up_hresp_o && up_hready_o == dn_hready_i));

  // R4
  local_err_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_hresp_o && !up_hready_o && !dn_hresp_i) |=> (up_hresp_o && up_hready_o));

  // R4
  seq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_hresp_o && up_hready_o && up_hsel_i && up_htrans_i == 2'd3 && !bypass_i && !$past(bypass_i))
      |-> dn_htrans_o == 2'd0);

  // R6
  nonseq_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_hready_o && up_hsel_i && up_htrans_i == 2'd2) |-> dn_htrans_o == 2'd2);

  // R10
  local_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_hresp_o && !dn_hresp_i) |-> up_hrdata_o == '0);

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_pass_chk: assert (up_hready_o == dn_hready_i && up_hresp_o == dn_hresp_i);
    end
  end
endmodule

bind ahb_err_cancel ecf_chk #(.DW(DW)) i_ecf_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bypass_i    (bypass_i),
  .up_hsel_i   (up_hsel_i),
  .up_htrans_i (up_htrans_i),
  .up_hrdata_o (up_hrdata_o),
  .up_hready_o (up_hready_o),
  .up_hresp_o  (up_hresp_o),
  .dn_htrans_o (dn_htrans_o),
  .dn_hready_i (dn_hready_i),
  .dn_hresp_i  (dn_hresp_i)
);

// File: tb/test_ahb_err_cancel.sv
module test_ahb_err_cancel;
  localparam int AW = 32;
  localparam int DW = 32;
  // R8 encodings
  localparam logic [1:0] T_IDLE = 2'd0, T_BUSY = 2'd1, T_NONSEQ = 2'd2, T_SEQ = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bypass = 1'b0;
  logic          sel = 1'b0;
  logic [1:0]    trans = T_IDLE;
  logic [AW-1:0] haddr = '0;
  logic          hwrite = 1'b0;
  logic [2:0]    hsize = 3'd2;
  logic [2:0]    hburst = 3'd3;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] up_rdata;
  logic          up_rdy, up_resp;
  logic [1:0]    dn_trans;
  logic [AW-1:0] dn_addr;
  logic          dn_write;
  logic [2:0]    dn_size, dn_burst;
  logic [DW-1:0] dn_wdata;
  logic [DW-1:0] dn_rdata = 32'h1000_0000;
  logic          dn_rdy = 1'b1;
  logic          dn_resp = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ahb_err_cancel #(.AW(AW), .DW(DW)) i_ahb_err_cancel (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass),
    .up_hsel_i(sel), .up_htrans_i(trans), .up_haddr_i(haddr), .up_hwrite_i(hwrite),
    .up_hsize_i(hsize), .up_hburst_i(hburst), .up_hwdata_i(hwdata),
    .up_hrdata_o(up_rdata), .up_hready_o(up_rdy), .up_hresp_o(up_resp),
    .dn_htrans_o(dn_trans), .dn_haddr_o(dn_addr), .dn_hwrite_o(dn_write),
    .dn_hsize_o(dn_size), .dn_hburst_o(dn_burst), .dn_hwdata_o(dn_wdata),
    .dn_hrdata_i(dn_rdata), .dn_hready_i(dn_rdy), .dn_hresp_i(dn_resp)
  );

  // behavioural reference: suppress flag, cancel flag, local error phase (0 none, 1 first, 2 second)
  bit m_sup, m_cancel, m_exit;
  int m_lerr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sup <= 0; m_cancel <= 0; m_lerr <= 0; m_exit <= 0;
    end else if (!m_sup) begin
      m_exit <= 0;
      if (!bypass && dn_resp && !dn_rdy) begin
        m_sup <= 1; m_cancel <= 1; m_lerr <= 0;
      end
    end else if (m_lerr == 1) begin
      m_lerr <= 2;
    end else if (m_cancel ? dn_rdy : 1'b1) begin
      m_cancel <= 0;
      if (!sel || trans == T_IDLE || trans == T_NONSEQ) begin
        m_sup <= 0; m_lerr <= 0; m_exit <= 1;
      end else if (trans == T_SEQ) m_lerr <= 1;
      else m_lerr <= 0;
    end
  end

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      bit loc;
      logic [1:0] e_tr;
      logic e_rdy, e_resp;
      logic [DW-1:0] e_rd;
      string tag;
      loc = m_sup && !m_cancel;
      if (!m_sup) e_tr = sel ? trans : T_IDLE;
      else if (m_lerr == 1) e_tr = T_IDLE;
      else e_tr = (sel && trans == T_NONSEQ) ? T_NONSEQ : T_IDLE;
      e_rdy  = loc ? (m_lerr != 1) : dn_rdy;
      e_resp = loc ? (m_lerr != 0) : dn_resp;
      e_rd   = loc ? '0 : dn_rdata;
      if (!rst_n) tag = "R9";
      else if (m_cancel) tag = "R2";
      else if (loc && m_lerr != 0) tag = "R4";
      else if (loc) tag = "R5";
      else if (m_exit) tag = "R6";
      else if (dn_resp) tag = "R3";
      else if (bypass) tag = "R7";
      else tag = "R1";
      check(tag, "dn_htrans", {30'd0, dn_trans}, {30'd0, e_tr});
      check(tag, "up_hready", {31'd0, up_rdy}, {31'd0, e_rdy});
      check(tag, "up_hresp", {31'd0, up_resp}, {31'd0, e_resp});
      check(loc ? "R10" : tag, "up_hrdata", up_rdata, e_rd);
      check("R1", "dn_haddr", dn_addr, haddr);
      check("R1", "dn_hwdata", dn_wdata, hwdata);
      check("R1", "dn_ctrl", {25'd0, dn_write, dn_size, dn_burst}, {25'd0, hwrite, hsize, hburst});
    end
  end

  task automatic cyc(input logic s, input logic [1:0] t, input logic [AW-1:0] a, input logic r, input logic rs);
    sel = s; trans = t; haddr = a; dn_rdy = r; dn_resp = rs;
    hwdata = ~a;
    dn_rdata = dn_rdata + 32'h0101_0101;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R1 watchdog act=hung exp=done");
      summary();
    end
  end

  initial begin
    // R9: reset state passes downstream response through
    cyc(0, T_IDLE, 0, 1, 0);
    cyc(0, T_IDLE, 0, 0, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: clean INCR4
    cyc(1, T_NONSEQ, 32'h100, 1, 0);
    cyc(1, T_SEQ,    32'h104, 1, 0);
    cyc(1, T_SEQ,    32'h108, 0, 0);
    cyc(1, T_SEQ,    32'h108, 1, 0);
    cyc(1, T_SEQ,    32'h10C, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);

    // R2 R3 R4: error on first beat of INCR4, master continues
    cyc(1, T_NONSEQ, 32'h200, 1, 0);
    cyc(1, T_SEQ,    32'h204, 0, 1);
    cyc(1, T_SEQ,    32'h204, 1, 1);
    cyc(1, T_SEQ,    32'h208, 1, 0);
    cyc(1, T_SEQ,    32'h208, 1, 0);
    cyc(1, T_SEQ,    32'h20C, 1, 0);
    cyc(1, T_SEQ,    32'h20C, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);  // R6 IDLE ends suppression
    cyc(1, T_IDLE,   32'h0,   1, 0);

    // R6: error on last beat, next burst NONSEQ in cancel cycle, back-to-back burst
    cyc(1, T_NONSEQ, 32'h300, 1, 0);
    cyc(1, T_SEQ,    32'h304, 1, 0);
    cyc(1, T_SEQ,    32'h308, 1, 0);
    cyc(1, T_SEQ,    32'h30C, 1, 0);
    cyc(1, T_NONSEQ, 32'h400, 0, 1);
    cyc(1, T_NONSEQ, 32'h400, 1, 1);
    cyc(1, T_SEQ,    32'h404, 1, 0);
    cyc(1, T_SEQ,    32'h408, 1, 0);
    cyc(1, T_SEQ,    32'h40C, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);

    // R7: buffered write with bypass, error forwarded, burst continues downstream
    bypass = 1'b1; hwrite = 1'b1;
    cyc(1, T_NONSEQ, 32'h500, 1, 0);
    cyc(1, T_SEQ,    32'h504, 0, 1);
    cyc(1, T_SEQ,    32'h504, 1, 1);
    cyc(1, T_SEQ,    32'h508, 1, 0);
    cyc(1, T_SEQ,    32'h50C, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);
    bypass = 1'b0; hwrite = 1'b0;

    // R5 R6: BUSY during suppression, exit through deselect, then new burst
    cyc(1, T_NONSEQ, 32'h600, 1, 0);
    cyc(1, T_SEQ,    32'h604, 0, 1);
    cyc(1, T_BUSY,   32'h604, 1, 1);
    cyc(1, T_SEQ,    32'h604, 1, 0);
    cyc(1, T_SEQ,    32'h608, 1, 0);
    cyc(1, T_SEQ,    32'h608, 1, 0);
    cyc(0, T_IDLE,   32'h0,   1, 0);
    cyc(0, T_IDLE,   32'h0,   1, 0);
    cyc(1, T_NONSEQ, 32'h700, 1, 0);
    cyc(1, T_SEQ,    32'h704, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);

    // R9: reset in the middle of a local error clears suppression
    cyc(1, T_NONSEQ, 32'h800, 1, 0);
    cyc(1, T_SEQ,    32'h804, 0, 1);
    cyc(1, T_SEQ,    32'h804, 1, 1);
    cyc(1, T_SEQ,    32'h808, 1, 0);
    rst_n = 1'b0;
    cyc(1, T_SEQ,    32'h808, 1, 0);
    rst_n = 1'b1;
    cyc(1, T_NONSEQ, 32'h900, 1, 0);
    cyc(1, T_IDLE,   32'h0,   1, 0);

    summary();
  end
endmodule